// File: doc/BRIEF.md
# Speculative Store Buffer with Youngest-Older Forwarding

This block sits between the load/store units of an out-of-order core and its first-level data cache. Stores that have executed but not yet committed are parked here as a circular queue in program order. Each slot carries a valid flag, a speculative flag, a data-present flag, the store's instruction number, its address and its data. A store may arrive with its data, or with only its address and have the data filled in later through a separate store-data port keyed by instruction number.

Commit and abort requests name a store by its instruction number. Commit makes the store non-speculative, and abort cancels it. Committed stores leave the buffer toward the cache strictly oldest first, one per cycle, through a valid/ready drain stream. Aborted slots are reclaimed when they reach the head. A load lookup returns data combinationally from the youngest buffered store that is older than the load and has the same address. The buffer copy takes priority over the cache. If that store has no data yet, the block flags a mis-speculation instead of a hit.

Back-pressure rules: the store-execute stream is accepted only on a cycle where `st_valid` and `st_ready` are both high. `st_ready` drops while every slot is occupied. On the drain stream, `dr_valid`, `dr_addr` and `dr_data` are held stable while `dr_ready` is low, and an entry leaves on the cycle both are high. Commit, abort, store-data and load lookup are plain strobes with no handshake.

Top module: `spec_store_buffer`

## Requirements
- R1: A store accepted on the execute stream occupies the next slot as valid and speculative, recording its instruction number and address, and its data when `st_has_data` is 1; the data becomes visible to loads on the following cycle.
- R2: `cmt_en` clears the speculative flag of the valid speculative entry whose instruction number equals `cmt_inum`; no other entry changes.
- R3: `abt_en` clears the valid flag of the valid speculative entry whose instruction number equals `abt_inum`; that entry then never forwards nor drains, and its slot is released when it becomes the oldest.
- R4: `sd_en` writes `sd_data` into the valid entry lacking data whose instruction number equals `sd_inum`, and marks it as holding data.
- R5: `dr_valid` is high exactly when the oldest occupied slot is valid, non-speculative and holds data; it then presents that entry's address and data, and the entry leaves on a `dr_valid`/`dr_ready` cycle, so stores reach the cache in program order, one per cycle.
- R6: With `ld_en` high, the load matches the youngest valid entry whose address equals `ld_addr` and whose instruction number is older than `ld_inum`; if that entry holds data, `ld_hit` is 1 and `ld_data` is its data, otherwise `ld_data` is 0.
- R7: Instruction number A is older than B when (A minus B) modulo 2^INUM_W has its top bit set, so age comparison works across wrap-around.
- R8: When the matched entry of R6 has no data, `ld_misspec` is 1 and `ld_hit` is 0.
- R9: `st_ready` is 0 exactly when all DEPTH slots are occupied (aborted slots not yet released count as occupied); a store offered then is not taken.
- R10: After reset the buffer is empty: `st_ready` is 1, `dr_valid` is 0.
- R11: With `ld_en` low, `ld_hit`, `ld_misspec` and `ld_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store-execute request |
| st_ready | output | 1 | Buffer can take a store |
| st_inum | input | INUM_W | Store instruction number |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_has_data | input | 1 | Store data is present with the request |
| cmt_en | input | 1 | Commit strobe |
| cmt_inum | input | INUM_W | Instruction number to commit |
| abt_en | input | 1 | Abort strobe |
| abt_inum | input | INUM_W | Instruction number to abort |
| sd_en | input | 1 | Late store-data strobe |
| sd_inum | input | INUM_W | Instruction number receiving data |
| sd_data | input | DATA_W | Late store data |
| ld_en | input | 1 | Load lookup enable |
| ld_addr | input | ADDR_W | Load address |
| ld_inum | input | INUM_W | Load instruction number |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_data | output | DATA_W | Forwarded data |
| ld_misspec | output | 1 | Matching older store has no data |
| dr_valid | output | 1 | Drain entry available |
| dr_ready | input | 1 | Cache accepts drain entry |
| dr_addr | output | ADDR_W | Drain address |
| dr_data | output | DATA_W | Drain data |

## Verification
Loads are tried against one address written by several stores, so the bench can tell youngest-older selection from oldest-match or any-match. Loads placed between those stores in age separate the older-than test from a plain address hit. A run where instruction numbers wrap past zero separates the modulo age rule from an unsigned compare. Commits arriving out of order with a stalled drain show that a speculative head blocks younger committed stores. Aborts and address-only stores show slot skipping and the mis-speculation flag. A long pseudo-random mix of all ports, compared every cycle against a queue model, catches interactions between strobes that land on the same cycle.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  // Condition of the oldest occupied slot, as seen by the queue controller.
  typedef enum logic [1:0] {
    HEAD_EMPTY = 2'd0,  // no occupied slot
    HEAD_SKIP  = 2'd1,  // slot cancelled, release without draining
    HEAD_WAIT  = 2'd2,  // still speculative or missing data
    HEAD_SEND  = 2'd3   // committed with data, offered to the cache
  } head_state_e;
endpackage

// File: rtl/ssb_entry_array.sv
module ssb_entry_array #(
  parameter int DEPTH  = 8,
  parameter int INUM_W = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  logic [INUM_W-1:0] new_inum,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [DATA_W-1:0] new_data,
  input  logic              new_has_data,
  input  logic              cmt_en,
  input  logic [INUM_W-1:0] cmt_inum,
  input  logic              abt_en,
  input  logic [INUM_W-1:0] abt_inum,
  input  logic              sd_en,
  input  logic [INUM_W-1:0] sd_inum,
  input  logic [DATA_W-1:0] sd_data,
  input  logic              free_en,
  input  logic [PTR_W-1:0]  free_idx,
  output logic              e_vld  [DEPTH],
  output logic              e_spec [DEPTH],
  output logic              e_dok  [DEPTH],
  output logic [INUM_W-1:0] e_inum [DEPTH],
  output logic [ADDR_W-1:0] e_addr [DEPTH],
  output logic [DATA_W-1:0] e_data [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              vld_q, spec_q, dok_q;
    logic [INUM_W-1:0] inum_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              take, drop, cmt_hit, abt_hit, fill_hit;

    assign take     = alloc_en && (alloc_idx == PTR_W'(i));
    assign drop     = free_en && (free_idx == PTR_W'(i));
    assign cmt_hit  = cmt_en && vld_q && spec_q && (inum_q == cmt_inum);
    assign abt_hit  = abt_en && vld_q && spec_q && (inum_q == abt_inum);
    assign fill_hit = sd_en && vld_q && !dok_q && (inum_q == sd_inum);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        spec_q <= 1'b0;
        dok_q  <= 1'b0;
        inum_q <= '0;
        addr_q <= '0;
        data_q <= '0;
      end else if (take) begin
        vld_q  <= 1'b1;
        spec_q <= 1'b1;
        dok_q  <= new_has_data;
        inum_q <= new_inum;
        addr_q <= new_addr;
        data_q <= new_has_data ? new_data : '0;
      end else if (drop) begin
        vld_q  <= 1'b0;
        spec_q <= 1'b0;
        dok_q  <= 1'b0;
      end else begin
        if (abt_hit) vld_q <= 1'b0;
        if (cmt_hit) spec_q <= 1'b0;
        if (fill_hit) begin
          dok_q  <= 1'b1;
          data_q <= sd_data;
        end
      end
    end

    assign e_vld[i]  = vld_q;
    assign e_spec[i] = spec_q;
    assign e_dok[i]  = dok_q;
    assign e_inum[i] = inum_q;
    assign e_addr[i] = addr_q;
    assign e_data[i] = data_q;
  end

endmodule

// File: rtl/ssb_fwd_select.sv
module ssb_fwd_select #(
  parameter int DEPTH  = 8,
  parameter int INUM_W = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]  head,
  input  logic              e_vld  [DEPTH],
  input  logic              e_dok  [DEPTH],
  input  logic [INUM_W-1:0] e_inum [DEPTH],
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  logic [DATA_W-1:0] e_data [DEPTH],
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [INUM_W-1:0] ld_inum,
  output logic              ld_hit,
  output logic              ld_misspec,
  output logic [DATA_W-1:0] ld_data
);

  logic             found;
  logic [PTR_W-1:0] sel;

  // Walk slots from oldest to youngest; the last qualifying slot wins,
  // which is the youngest store still older than the load.
  always_comb begin
    logic [PTR_W-1:0]  slot;
    logic [INUM_W-1:0] age_gap;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot    = head + PTR_W'(k);
      age_gap = e_inum[slot] - ld_inum;
      if (e_vld[slot] && (e_addr[slot] == ld_addr) && age_gap[INUM_W-1]) begin
        found = 1'b1;
        sel   = slot;
      end
    end
  end

  assign ld_hit     = ld_en && found && e_dok[sel];
  assign ld_misspec = ld_en && found && !e_dok[sel];
  assign ld_data    = ld_hit ? e_data[sel] : '0;

endmodule

// File: rtl/ssb_queue_ctrl.sv
module ssb_queue_ctrl
  import ssb_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic             head_vld,
  input  logic             head_spec,
  input  logic             head_dok,
  input  logic             dr_ready,
  output logic             dr_valid,
  output logic             push,
  output logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  head_state_e      hstate;

  always_comb begin
    if (cnt_q == '0)              hstate = HEAD_EMPTY;
    else if (!head_vld)           hstate = HEAD_SKIP;
    else if (head_spec || !head_dok) hstate = HEAD_WAIT;
    else                          hstate = HEAD_SEND;
  end

  assign st_ready = (cnt_q != CNT_W'(DEPTH));
  assign dr_valid = (hstate == HEAD_SEND);
  assign push     = st_valid && st_ready;
  assign pop      = (hstate == HEAD_SKIP) || (dr_valid && dr_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + PTR_W'(1);
      if (pop)  head_q <= head_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head = head_q;
  assign tail = tail_q;

endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer #(
  parameter int DEPTH  = 8,
  parameter int INUM_W = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [INUM_W-1:0] st_inum,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_has_data,
  input  logic              cmt_en,
  input  logic [INUM_W-1:0] cmt_inum,
  input  logic              abt_en,
  input  logic [INUM_W-1:0] abt_inum,
  input  logic              sd_en,
  input  logic [INUM_W-1:0] sd_inum,
  input  logic [DATA_W-1:0] sd_data,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [INUM_W-1:0] ld_inum,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_misspec,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [DATA_W-1:0] dr_data
);

  localparam int PTR_W = $clog2(DEPTH);

  logic              e_vld  [DEPTH];
  logic              e_spec [DEPTH];
  logic              e_dok  [DEPTH];
  logic [INUM_W-1:0] e_inum [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];

  logic             q_push, q_pop;
  logic [PTR_W-1:0] q_head, q_tail;

  ssb_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .head_vld  (e_vld[q_head]),
    .head_spec (e_spec[q_head]),
    .head_dok  (e_dok[q_head]),
    .dr_ready  (dr_ready),
    .dr_valid  (dr_valid),
    .push      (q_push),
    .pop       (q_pop),
    .head      (q_head),
    .tail      (q_tail)
  );

  ssb_entry_array #(
    .DEPTH(DEPTH), .INUM_W(INUM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (q_push),
    .alloc_idx    (q_tail),
    .new_inum     (st_inum),
    .new_addr     (st_addr),
    .new_data     (st_data),
    .new_has_data (st_has_data),
    .cmt_en       (cmt_en),
    .cmt_inum     (cmt_inum),
    .abt_en       (abt_en),
    .abt_inum     (abt_inum),
    .sd_en        (sd_en),
    .sd_inum      (sd_inum),
    .sd_data      (sd_data),
    .free_en      (q_pop),
    .free_idx     (q_head),
    .e_vld        (e_vld),
    .e_spec       (e_spec),
    .e_dok        (e_dok),
    .e_inum       (e_inum),
    .e_addr       (e_addr),
    .e_data       (e_data)
  );

  ssb_fwd_select #(
    .DEPTH(DEPTH), .INUM_W(INUM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fwd (
    .head       (q_head),
    .e_vld      (e_vld),
    .e_dok      (e_dok),
    .e_inum     (e_inum),
    .e_addr     (e_addr),
    .e_data     (e_data),
    .ld_en      (ld_en),
    .ld_addr    (ld_addr),
    .ld_inum    (ld_inum),
    .ld_hit     (ld_hit),
    .ld_misspec (ld_misspec),
    .ld_data    (ld_data)
  );

  assign dr_addr = e_addr[q_head];
  assign dr_data = e_data[q_head];

endmodule

// File: rtl/ssb_chk.sv
module ssb_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              dr_valid,
  input logic              dr_ready,
  input logic [ADDR_W-1:0] dr_addr,
  input logic [DATA_W-1:0] dr_data,
  input logic              ld_en,
  input logic              ld_hit,
  input logic              ld_misspec,
  input logic              head_pop
);

  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CNT_W'(st_valid && st_ready) - CNT_W'(head_pop);
  end

  // R9
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready == (occ != CNT_W'(DEPTH)));

  // R5
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data));

  // R5
  drain_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && dr_ready |-> head_pop);

  // R8
  misspec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_misspec |-> !ld_hit);

  // R11
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |-> !ld_hit && !ld_misspec);

endmodule

bind spec_store_buffer ssb_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .dr_valid   (dr_valid),
  .dr_ready   (dr_ready),
  .dr_addr    (dr_addr),
  .dr_data    (dr_data),
  .ld_en      (ld_en),
  .ld_hit     (ld_hit),
  .ld_misspec (ld_misspec),
  .head_pop   (q_pop)
);

// File: tb/tb_spec_store_buffer.sv
module tb_spec_store_buffer;
  localparam int DEPTH = 8;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          st_valid = 0, st_has_data = 0, cmt_en = 0, abt_en = 0, sd_en = 0;
  logic          ld_en = 0, dr_ready = 0;
  logic [IW-1:0] st_inum = 0, cmt_inum = 0, abt_inum = 0, sd_inum = 0, ld_inum = 0;
  logic [31:0]   st_addr = 0, st_data = 0, sd_data = 0, ld_addr = 0;
  logic          st_ready, ld_hit, ld_misspec, dr_valid;
  logic [31:0]   ld_data, dr_addr, dr_data;

  spec_store_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_inum(st_inum), .st_addr(st_addr),
    .st_data(st_data), .st_has_data(st_has_data),
    .cmt_en(cmt_en), .cmt_inum(cmt_inum), .abt_en(abt_en), .abt_inum(abt_inum),
    .sd_en(sd_en), .sd_inum(sd_inum), .sd_data(sd_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_inum(ld_inum),
    .ld_hit(ld_hit), .ld_data(ld_data), .ld_misspec(ld_misspec),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data)
  );

  typedef struct {
    bit vld; bit spec; bit dok;
    logic [IW-1:0] inum; logic [31:0] addr; logic [31:0] data;
  } ment_t;
  ment_t mq[$];

  int total = 0, bad = 0;
  bit done = 0;
  logic [IW-1:0] nxt = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R7: a is older than b when (a-b) mod 2^IW has its top bit set
  function automatic bit older(logic [IW-1:0] a, logic [IW-1:0] b);
    logic [IW-1:0] d;
    d = a - b;
    return d[IW-1];
  endfunction

  function automatic bit m_drv();
    return mq.size() > 0 && mq[0].vld && !mq[0].spec && mq[0].dok;
  endfunction

  task automatic compare();
    bit f, h, ms; logic [31:0] d;
    f = 0;
    d = 0;
    h = 0;
    ms = 0;
    foreach (mq[i])
      if (mq[i].vld && mq[i].addr == ld_addr && older(mq[i].inum, ld_inum)) begin
        f = 1; h = mq[i].dok; d = mq[i].data;
      end
    if (!ld_en) f = 0;
    ms = f && !h;
    h  = f && h;
    if (!h) d = 0;
    chk("R9 st_ready", st_ready, (mq.size() < DEPTH));
    chk("R5 dr_valid", dr_valid, m_drv());
    if (m_drv()) begin
      chk("R5 dr_addr", dr_addr, mq[0].addr);
      chk("R5 dr_data", dr_data, mq[0].data);
    end
    chk("R6 ld_hit", ld_hit, h);
    chk("R6 ld_data", ld_data, d);
    chk("R8 ld_misspec", ld_misspec, ms);
  endtask

  task automatic settle();
    #5;
    compare();
  endtask

  task automatic tick();
    bit push, pop;
    ment_t e;
    push = st_valid && (mq.size() < DEPTH);
    pop  = mq.size() > 0 && (!mq[0].vld || (m_drv() && dr_ready));
    @(posedge clk);
    foreach (mq[i]) begin
      bit c, a, s;
      c = cmt_en && mq[i].vld && mq[i].spec && mq[i].inum == cmt_inum;
      a = abt_en && mq[i].vld && mq[i].spec && mq[i].inum == abt_inum;
      s = sd_en && mq[i].vld && !mq[i].dok && mq[i].inum == sd_inum;
      if (a) mq[i].vld = 0;
      if (c) mq[i].spec = 0;
      if (s) begin mq[i].dok = 1; mq[i].data = sd_data; end
    end
    if (pop) void'(mq.pop_front());
    if (push) begin
      e.vld = 1; e.spec = 1; e.dok = st_has_data; e.inum = st_inum;
      e.addr = st_addr; e.data = st_has_data ? st_data : 32'h0;
      mq.push_back(e);
      nxt = st_inum + 1'b1;
    end
    @(negedge clk);
    st_valid = 0; cmt_en = 0; abt_en = 0; sd_en = 0; ld_en = 0;
  endtask

  task automatic cyc();
    settle();
    tick();
  endtask

  task automatic store(logic [IW-1:0] n, logic [31:0] a, logic [31:0] d, bit hd);
    st_valid = 1; st_inum = n; st_addr = a; st_data = d; st_has_data = hd;
    cyc();
  endtask

  task automatic load(logic [IW-1:0] n, logic [31:0] a);
    ld_en = 1; ld_inum = n; ld_addr = a;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    #5;
    chk("R10 st_ready after reset", st_ready, 1);
    chk("R10 dr_valid after reset", dr_valid, 0);
    @(negedge clk);

    // Four stores, two to 0x100; inum 1..4
    store(6'd1, 32'h100, 32'hA1, 1);
    store(6'd2, 32'h200, 32'hB2, 1);
    store(6'd3, 32'h100, 32'hA3, 1);
    store(6'd4, 32'h300, 32'hC4, 1);
    load(6'd5, 32'h100); settle();
    chk("R6 youngest older store", ld_data, 32'hA3);
    tick();
    load(6'd3, 32'h100); settle();
    chk("R6 skip non-older store", ld_data, 32'hA1);
    tick();
    load(6'd1, 32'h100); settle();
    chk("R6 same inum is not older", ld_hit, 0);
    tick();
    load(6'd5, 32'h400); settle();
    chk("R1 unknown address misses", ld_hit, 0);
    tick();
    ld_addr = 32'h100; ld_inum = 6'd5; settle();
    chk("R11 disabled lookup quiet", ld_hit, 0);
    tick();

    // Out-of-order commit: 3 first, head (1) still speculative
    cmt_en = 1; cmt_inum = 6'd3; cyc();
    settle();
    chk("R2 younger commit does not drain", dr_valid, 0);
    tick();
    cmt_en = 1; cmt_inum = 6'd1; cyc();
    dr_ready = 0; settle();
    chk("R5 head committed offers drain", dr_valid, 1);
    chk("R5 oldest first", dr_addr, 32'h100);
    tick(); tick();
    // Abort 2 while 1 drains
    abt_en = 1; abt_inum = 6'd2; cyc();
    load(6'd5, 32'h200); settle();
    chk("R3 aborted store does not forward", ld_hit, 0);
    tick();
    dr_ready = 1;
    repeat (4) cyc();
    dr_ready = 0;
    cmt_en = 1; cmt_inum = 6'd4; cyc();
    dr_ready = 1; cyc(); cyc();

    // Address-only store and late data
    store(6'd6, 32'h500, 32'h0, 0);
    load(6'd7, 32'h500); settle();
    chk("R8 no data flags misspec", ld_misspec, 1);
    tick();
    sd_en = 1; sd_inum = 6'd6; sd_data = 32'hD6; cyc();
    load(6'd7, 32'h500); settle();
    chk("R4 late data forwarded", ld_data, 32'hD6);
    tick();
    cmt_en = 1; cmt_inum = 6'd6; cyc(); cyc(); cyc();

    // Wrap of instruction numbers: 62, 63, 0
    store(6'd62, 32'h600, 32'hE0, 1);
    store(6'd63, 32'h600, 32'hE1, 1);
    store(6'd0, 32'h600, 32'hE2, 1);
    load(6'd1, 32'h600); settle();
    chk("R7 wrap youngest older", ld_data, 32'hE2);
    tick();
    load(6'd0, 32'h600); settle();
    chk("R7 63 older than 0", ld_data, 32'hE1);
    tick();

    // Fill to full with drain stalled
    dr_ready = 0;
    for (int k = 1; k <= 6; k++) store(IW'(k), 32'h700 + k, 32'hF0 + k, 1);
    settle();
    chk("R9 full drops ready", st_ready, 0);
    tick();
    store(6'd7, 32'h800, 32'h77, 1);
    load(6'd8, 32'h800); settle();
    chk("R9 store offered while full not taken", ld_hit, 0);
    tick();
    for (int k = 62; k <= 69; k++) begin cmt_en = 1; cmt_inum = IW'(k); cyc(); end
    dr_ready = 1;
    repeat (10) cyc();
    nxt = 6'd7;

    // Pseudo-random mix
    for (int t = 0; t < 600; t++) begin
      if ($urandom_range(0, 2) != 0) begin
        st_valid = 1; st_inum = nxt; st_addr = 32'h900 + $urandom_range(0, 3);
        st_data = $urandom; st_has_data = $urandom_range(0, 3) != 0;
      end
      if (mq.size() > 0 && $urandom_range(0, 1) == 1) begin
        cmt_en = 1; cmt_inum = mq[$urandom_range(0, mq.size() - 1)].inum;
      end
      if (mq.size() > 0 && $urandom_range(0, 9) == 0) begin
        abt_en = 1; abt_inum = mq[$urandom_range(0, mq.size() - 1)].inum;
      end
      if (mq.size() > 0 && $urandom_range(0, 1) == 1) begin
        sd_en = 1; sd_inum = mq[$urandom_range(0, mq.size() - 1)].inum; sd_data = $urandom;
      end
      if ($urandom_range(0, 3) != 0)
        load(nxt - IW'($urandom_range(0, 6)), 32'h900 + $urandom_range(0, 3));
      dr_ready = $urandom_range(0, 2) != 0;
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule